// File: doc/BRIEF.md
# Per-Channel RGB Color Correction Table with Serial Register Access

This block sits in a 24-bit RGB pixel stream and remaps each color component through its own 256-entry, 8-bit lookup table. Red, green and blue each have a separate table, so gamma, white-point or gain correction can be set independently per channel. Each incoming pixel is captured on the rising pixel clock together with its horizontal sync, vertical sync and data-enable qualifiers. The corrected pixel comes out one pixel clock later, and the qualifiers are delayed by the same amount.

The tables and a single enable bit are loaded through a four-wire serial slave port (clock, active-low select, data in, data out). The port is oversampled in the pixel clock domain, so every register write takes effect in that domain. Each table is reached indirectly through two registers: a pointer register and a data port. Every byte written to a data port lands at the pointer, and the pointer then advances. A single framed burst can therefore load a whole table. When the enable bit is clear, pixels pass through unchanged with the same latency.

Top module: `pix_lut_corrector`

## Requirements
- R1: A serial frame is framed by `spi_cs_n` low. Bits are sampled on rising `spi_sclk`, MSB first. The first bit selects the direction (0 = write, 1 = read), the next 7 bits give the register address, and any further bits form data bytes.
- R2: Registers 0x01, 0x03 and 0x05 are the red, green and blue table pointers. Writing sets the pointer. Reading returns its current value.
- R3: Registers 0x02, 0x04 and 0x06 are the red, green and blue data ports. Each byte written stores into that channel's table at the pointer, then increments the pointer, wrapping from 0xFF to 0x00.
- R4: A write frame may carry up to 256 data bytes, all sent to the addressed register. Bytes after the 256th in the same frame are ignored.
- R5: In a read frame, the 8-bit value of the addressed register appears on `spi_miso` MSB first, one bit per clock, beginning with the rising `spi_sclk` after the address. Reading a data port returns the table entry at the pointer and leaves the pointer unchanged.
- R6: Bit 0 of register 0x07 is the correction enable. It reads back as {7'b0, enable}. Register 0x00 and registers 0x08 to 0x7F are reserved: writes to them change nothing, and reads return 0x00.
- R7: With the enable set, `out_rgb` equals {red_table[in_rgb[23:16]], green_table[in_rgb[15:8]], blue_table[in_rgb[7:0]]} one pixel clock after the input was sampled.
- R8: With the enable clear, `out_rgb` equals `in_rgb` one pixel clock after sampling.
- R9: `out_hs`, `out_vs` and `out_de` equal `in_hs`, `in_vs` and `in_de` delayed by exactly one pixel clock.
- R10: Raising `spi_cs_n` ends a frame at once. An incomplete byte is discarded and causes no write.
- R11: After reset, the outputs are zero, the enable is clear and all three pointers are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Pixel clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_cs_n | input | 1 | Serial frame select, active low |
| spi_mosi | input | 1 | Serial data into the block |
| spi_miso | output | 1 | Serial read data, 0 outside a frame |
| in_rgb | input | 24 | Pixel in: red 23:16, green 15:8, blue 7:0 |
| in_hs | input | 1 | Horizontal sync in |
| in_vs | input | 1 | Vertical sync in |
| in_de | input | 1 | Data enable in |
| out_rgb | output | 24 | Corrected or bypassed pixel, same channel layout |
| out_hs | output | 1 | Horizontal sync, one clock delayed |
| out_vs | output | 1 | Vertical sync, one clock delayed |
| out_de | output | 1 | Data enable, one clock delayed |

## Verification
The tables are filled with three different generated curves: an affine ramp, an inverted ramp and a scrambled ramp. A channel swap or an indexing slip in the pixel path therefore shows up as a wrong value. Pixels are tried at all-zero, all-ones, mixed per-channel values and a pseudo-random run, first in bypass and then with correction on, which separates the pass-through path from the lookup path. Further cases cover a 257-byte burst, a pointer wrap that straddles 0xFF, an aborted frame, and writes to reserved addresses and reserved control bits. Each of these touches state that is then read back through the serial port or seen on the pixels.

// File: rtl/plut_pkg.sv
package plut_pkg;
  localparam int BYTE_W   = 8;
  localparam int REG_AW   = 7;
  localparam int N_CHAN   = 3;

  localparam logic [REG_AW-1:0] REG_CTRL = 7'h07;

  // channel served by a pointer or data-port address, or -1 if none
  function automatic int chan_of(input logic [REG_AW-1:0] a);
    if (a >= 7'h01 && a <= 7'h06) return (int'(a) - 1) / 2;
    return -1;
  endfunction

  function automatic logic is_ptr_reg(input logic [REG_AW-1:0] a);
    return (chan_of(a) >= 0) && a[0];
  endfunction

  function automatic logic is_port_reg(input logic [REG_AW-1:0] a);
    return (chan_of(a) >= 0) && !a[0];
  endfunction

  // pointer advance; wraps naturally at the table depth
  function automatic logic [BYTE_W-1:0] ptr_next(input logic [BYTE_W-1:0] p);
    return p + 1'b1;
  endfunction
endpackage

// File: rtl/plut_spi_rx.sv
module plut_spi_rx #(
  parameter int SYNC     = 2,
  parameter int PAGE_MAX = 256
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk,
  input  logic                      cs_n,
  input  logic                      sdi,
  output logic                      sdo,
  output logic                      wr_stb,
  output logic [plut_pkg::REG_AW-1:0] wr_addr,
  output logic [plut_pkg::BYTE_W-1:0] wr_data,
  output logic [plut_pkg::REG_AW-1:0] rd_addr,
  input  logic [plut_pkg::BYTE_W-1:0] rd_data
);
  import plut_pkg::*;
  localparam int CNT_W = $clog2(PAGE_MAX + 1);

  logic [SYNC:0]   sclk_q;
  logic [SYNC-1:0] cs_q, sdi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_q <= '0;
      cs_q   <= '1;
      sdi_q  <= '0;
    end else begin
      sclk_q <= {sclk_q[SYNC-1:0], sclk};
      cs_q   <= {cs_q[SYNC-2:0], cs_n};
      sdi_q  <= {sdi_q[SYNC-2:0], sdi};
    end
  end

  // named events for the checks
  logic sclk_rise, sclk_fall, cs_act, sdi_b;
  assign sclk_rise = sclk_q[SYNC-1] & ~sclk_q[SYNC];
  assign sclk_fall = ~sclk_q[SYNC-1] & sclk_q[SYNC];
  assign cs_act    = ~cs_q[SYNC-1];
  assign sdi_b     = sdi_q[SYNC-1];

  logic [2:0]          bit_cnt;
  logic [BYTE_W-1:0]   rx_sr, tx_sr, byte_now;
  logic                hdr_done, is_rd, load_pend, skip_fall;
  logic [REG_AW-1:0]   addr_q;
  logic [CNT_W-1:0]    page_cnt;
  logic                byte_done, hdr_evt, data_evt;

  assign byte_now  = {rx_sr[BYTE_W-2:0], sdi_b};
  assign byte_done = cs_act && sclk_rise && (bit_cnt == 3'd7);
  assign hdr_evt   = byte_done && !hdr_done;
  assign data_evt  = byte_done && hdr_done && !is_rd;

  assign wr_stb  = data_evt && (page_cnt < CNT_W'(PAGE_MAX));
  assign wr_addr = addr_q;
  assign wr_data = byte_now;
  assign rd_addr = addr_q;
  assign sdo     = cs_act & tx_sr[BYTE_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n || !cs_act) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      hdr_done  <= 1'b0;
      is_rd     <= 1'b0;
      load_pend <= 1'b0;
      skip_fall <= 1'b0;
      page_cnt  <= '0;
      if (!rst_n) addr_q <= '0;
    end else begin
      if (sclk_rise) begin
        rx_sr   <= byte_now;
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (hdr_evt) begin
        hdr_done  <= 1'b1;
        is_rd     <= byte_now[BYTE_W-1];
        addr_q    <= byte_now[REG_AW-1:0];
        load_pend <= byte_now[BYTE_W-1];
      end
      if (wr_stb) page_cnt <= page_cnt + 1'b1;
      if (load_pend) begin
        tx_sr     <= rd_data;
        load_pend <= 1'b0;
        skip_fall <= 1'b1;
      end else if (sclk_fall && is_rd) begin
        if (skip_fall) skip_fall <= 1'b0;
        else           tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end

  // R10
  frame_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (!hdr_done && bit_cnt == 3'd0 && !wr_stb));
  // R4
  page_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_cnt <= CNT_W'(PAGE_MAX));
  // R5
  rd_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pend && cs_act) |=> (tx_sr == $past(rd_data)));
endmodule

// File: rtl/plut_bank.sv
module plut_bank #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ptr_we,
  input  logic          data_we,
  input  logic [CW-1:0] wdata,
  input  logic [CW-1:0] pix_idx,
  output logic [CW-1:0] ptr_q,
  output logic [CW-1:0] spi_entry,
  output logic [CW-1:0] pix_entry
);
  localparam int DEPTH = 1 << CW;

  logic [CW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n)       ptr_q <= '0;
    else if (ptr_we)  ptr_q <= wdata;
    else if (data_we) ptr_q <= ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (data_we) mem[ptr_q] <= wdata;
  end

  assign spi_entry = mem[ptr_q];
  assign pix_entry = mem[pix_idx];

  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ptr_we && ptr_q == '1) |=> (ptr_q == '0));
  // R2
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> (ptr_q == $past(wdata)));
  // R3
  port_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_we && !ptr_we) |=> (mem[$past(ptr_q)] == $past(wdata)));
endmodule

// File: rtl/plut_regs.sv
module plut_regs #(
  parameter int CW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_stb,
  input  logic [plut_pkg::REG_AW-1:0] wr_addr,
  input  logic [plut_pkg::BYTE_W-1:0] wr_data,
  input  logic [plut_pkg::REG_AW-1:0] rd_addr,
  output logic [plut_pkg::BYTE_W-1:0] rd_data,
  input  logic [3*CW-1:0]             pix_rgb,
  output logic [3*CW-1:0]             pix_lut,
  output logic                        lut_en
);
  import plut_pkg::*;

  logic [N_CHAN-1:0]  ptr_we_v, data_we_v;
  logic [CW-1:0]      ptr_v   [N_CHAN];
  logic [CW-1:0]      entry_v [N_CHAN];

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    // channel 0 (red) occupies the top bits
    localparam int LSB = (N_CHAN - 1 - c) * CW;
    assign ptr_we_v[c]  = wr_stb && is_ptr_reg(wr_addr)  && chan_of(wr_addr) == c;
    assign data_we_v[c] = wr_stb && is_port_reg(wr_addr) && chan_of(wr_addr) == c;

    plut_bank #(.CW(CW)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .ptr_we    (ptr_we_v[c]),
      .data_we   (data_we_v[c]),
      .wdata     (wr_data[CW-1:0]),
      .pix_idx   (pix_rgb[LSB +: CW]),
      .ptr_q     (ptr_v[c]),
      .spi_entry (entry_v[c]),
      .pix_entry (pix_lut[LSB +: CW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                            lut_en <= 1'b0;
    else if (wr_stb && wr_addr == REG_CTRL) lut_en <= wr_data[0];
  end

  always_comb begin
    rd_data = '0;
    if (is_ptr_reg(rd_addr))       rd_data = BYTE_W'(ptr_v[chan_of(rd_addr)]);
    else if (is_port_reg(rd_addr)) rd_data = BYTE_W'(entry_v[chan_of(rd_addr)]);
    else if (rd_addr == REG_CTRL)  rd_data = {{(BYTE_W-1){1'b0}}, lut_en};
  end

  // R3
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(data_we_v | ptr_we_v));
  // R6
  rsvd_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && (wr_addr == 7'h00 || wr_addr > REG_CTRL)) |=> $stable(lut_en));
endmodule

// File: rtl/pix_lut_corrector.sv
module pix_lut_corrector #(
  parameter int CW       = 8,
  parameter int SYNC     = 2,
  parameter int PAGE_MAX = 256
) (
  input  logic          pclk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs_n,
  input  logic          spi_mosi,
  output logic          spi_miso,
  input  logic [23:0]   in_rgb,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic          in_de,
  output logic [23:0]   out_rgb,
  output logic          out_hs,
  output logic          out_vs,
  output logic          out_de
);
  import plut_pkg::*;
  localparam int RGB_W = 3 * CW;

  logic                wr_stb;
  logic [REG_AW-1:0]   wr_addr, rd_addr;
  logic [BYTE_W-1:0]   wr_data, rd_data;
  logic [RGB_W-1:0]    lut_rgb;
  logic                lut_en;

  plut_spi_rx #(.SYNC(SYNC), .PAGE_MAX(PAGE_MAX)) rx_i (
    .clk     (pclk),
    .rst_n   (rst_n),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .sdi     (spi_mosi),
    .sdo     (spi_miso),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  plut_regs #(.CW(CW)) regs_i (
    .clk     (pclk),
    .rst_n   (rst_n),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pix_rgb (in_rgb),
    .pix_lut (lut_rgb),
    .lut_en  (lut_en)
  );

  always_ff @(posedge pclk) begin
    if (!rst_n) begin
      out_rgb <= '0;
      out_hs  <= 1'b0;
      out_vs  <= 1'b0;
      out_de  <= 1'b0;
    end else begin
      out_rgb <= lut_en ? lut_rgb : in_rgb;
      out_hs  <= in_hs;
      out_vs  <= in_vs;
      out_de  <= in_de;
    end
  end

  // R9
  ctl_delay_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    1'b1 |=> (out_hs == $past(in_hs) && out_vs == $past(in_vs) && out_de == $past(in_de)));
  // R8
  bypass_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    !lut_en |=> (out_rgb == $past(in_rgb)));
  // R7
  corrected_chk: assert property (@(posedge pclk) disable iff (!rst_n)
    (lut_en && !wr_stb) |=> (out_rgb == $past(lut_rgb)));
endmodule

// File: tb/pix_lut_corrector_tb_top.sv
module pix_lut_corrector_tb_top;
  logic pclk = 0, rst_n = 0;
  logic spi_sclk = 0, spi_cs_n = 1, spi_mosi = 0, spi_miso;
  logic [23:0] in_rgb = '0, out_rgb;
  logic in_hs = 0, in_vs = 0, in_de = 0, out_hs, out_vs, out_de;

  int total = 0, bad = 0;
  bit done = 0;
  int exp_lut [3][256];

  always #10 pclk = ~pclk;

  pix_lut_corrector dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic spi_bit(input logic b, output logic so);
    spi_sclk = 0; spi_mosi = b;
    repeat (5) @(negedge pclk);
    so = spi_miso; spi_sclk = 1;
    repeat (5) @(negedge pclk);
  endtask

  task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spi_bit(tx[i], rx[i]);
  endtask

  task automatic spi_begin();
    @(negedge pclk); spi_cs_n = 0; repeat (5) @(negedge pclk);
  endtask

  task automatic spi_end();
    spi_sclk = 0; repeat (5) @(negedge pclk);
    spi_cs_n = 1; repeat (12) @(negedge pclk);
  endtask

  task automatic reg_wr(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] rx;
    spi_begin(); spi_byte({1'b0, a}, rx); spi_byte(d, rx); spi_end();
  endtask

  task automatic reg_rd(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] rx;
    spi_begin(); spi_byte({1'b1, a}, rx); spi_byte(8'h00, d); spi_end();
  endtask

  task automatic pix_chk(input string req, input logic [23:0] rgb, input logic [2:0] ctl,
                         input logic [23:0] exp);
    @(negedge pclk);
    in_rgb = rgb; {in_hs, in_vs, in_de} = ctl;
    @(negedge pclk);
    chk(req, out_rgb, exp);
    chk("R9", {out_hs, out_vs, out_de}, ctl);
  endtask

  function automatic logic [23:0] lut_of(input logic [23:0] p);
    return {8'(exp_lut[0][p[23:16]]), 8'(exp_lut[1][p[15:8]]), 8'(exp_lut[2][p[7:0]])};
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk("R11 rgb", out_rgb, 0);
    chk("R11 ctl", {out_hs, out_vs, out_de}, 0);
    reg_rd(7'h07, d); chk("R11 enable", d, 0);
    reg_rd(7'h01, d); chk("R11 red ptr", d, 0);
    reg_rd(7'h03, d); chk("R11 green ptr", d, 0);
    reg_rd(7'h05, d); chk("R11 blue ptr", d, 0);
  endtask

  task automatic t_pointers();
    logic [7:0] d;
    reg_wr(7'h01, 8'h10); reg_rd(7'h01, d); chk("R2 red ptr", d, 8'h10);
    reg_wr(7'h03, 8'hA5); reg_rd(7'h03, d); chk("R2 green ptr", d, 8'hA5);
    reg_wr(7'h05, 8'h3C); reg_rd(7'h05, d); chk("R2 blue ptr", d, 8'h3C);
  endtask

  task automatic t_fill();
    logic [7:0] rx, d;
    for (int c = 0; c < 3; c++) reg_wr(7'(2 * c + 1), 8'h00);
    // red: 257 bytes, the last must be dropped (R4)
    spi_begin(); spi_byte(8'h02, rx);
    for (int i = 0; i < 257; i++) begin
      logic [7:0] v = (i < 256) ? 8'((i * 7 + 8'h33) & 8'hFF) : 8'hEE;
      spi_byte(v, rx);
      if (i < 256) exp_lut[0][i] = v;
    end
    spi_end();
    spi_begin(); spi_byte(8'h04, rx);
    for (int i = 0; i < 256; i++) begin
      exp_lut[1][i] = 255 - i; spi_byte(8'(255 - i), rx);
    end
    spi_end();
    spi_begin(); spi_byte(8'h06, rx);
    for (int i = 0; i < 256; i++) begin
      exp_lut[2][i] = ((i * 3 + 7) & 8'hFF) ^ 8'hA5; spi_byte(8'(exp_lut[2][i]), rx);
    end
    spi_end();
    reg_rd(7'h01, d); chk("R4 red ptr after 257 bytes", d, 0);
    reg_rd(7'h02, d); chk("R4 entry 0 kept", d, exp_lut[0][0]);
    reg_rd(7'h01, d); chk("R5 read leaves ptr", d, 0);
    reg_wr(7'h05, 8'h80);
    reg_rd(7'h06, d); chk("R5 blue entry 0x80", d, exp_lut[2][128]);
  endtask

  task automatic t_wrap();
    logic [7:0] rx, d;
    reg_wr(7'h03, 8'hFE);
    spi_begin(); spi_byte(8'h04, rx);
    spi_byte(8'h11, rx); spi_byte(8'h22, rx); spi_byte(8'h33, rx);
    spi_end();
    exp_lut[1][254] = 8'h11; exp_lut[1][255] = 8'h22; exp_lut[1][0] = 8'h33;
    reg_rd(7'h03, d); chk("R3 wrap ptr", d, 1);
    reg_wr(7'h03, 8'h00);
    reg_rd(7'h04, d); chk("R3 wrapped entry 0", d, 8'h33);
  endtask

  task automatic t_bypass();
    pix_chk("R8 zero", 24'h000000, 3'b000, 24'h000000);
    pix_chk("R8 ones", 24'hFFFFFF, 3'b111, 24'hFFFFFF);
    pix_chk("R8 mixed", 24'h01FE80, 3'b101, 24'h01FE80);
  endtask

  task automatic t_enable();
    logic [7:0] d;
    logic [23:0] p = 24'h123456;
    reg_wr(7'h07, 8'h01); reg_rd(7'h07, d); chk("R6 enable read", d, 1);
    pix_chk("R7 zero", 24'h000000, 3'b001, lut_of(24'h000000));
    pix_chk("R7 ones", 24'hFFFFFF, 3'b110, lut_of(24'hFFFFFF));
    pix_chk("R7 mixed", 24'h01FE80, 3'b011, lut_of(24'h01FE80));
    for (int i = 0; i < 8; i++) begin
      p = p * 24'd1103 + 24'd12345;
      pix_chk("R7 random", p, 3'(i), lut_of(p));
    end
  endtask

  task automatic t_reserved();
    logic [7:0] d;
    reg_wr(7'h00, 8'hFF); reg_wr(7'h08, 8'h00); reg_wr(7'h7F, 8'h00);
    reg_rd(7'h00, d); chk("R6 reserved 0x00 read", d, 0);
    reg_rd(7'h08, d); chk("R6 reserved 0x08 read", d, 0);
    reg_rd(7'h07, d); chk("R6 enable kept", d, 1);
    pix_chk("R6 still corrected", 24'hA0B0C0, 3'b001, lut_of(24'hA0B0C0));
    reg_wr(7'h07, 8'hFE); reg_rd(7'h07, d); chk("R6 only bit 0", d, 0);
    pix_chk("R8 bypass again", 24'hA0B0C0, 3'b001, 24'hA0B0C0);
  endtask

  task automatic t_abort();
    logic [7:0] rx, d;
    logic so;
    reg_wr(7'h01, 8'h44);
    spi_begin(); spi_byte(8'h01, rx);
    for (int i = 0; i < 4; i++) spi_bit(1'b1, so);
    spi_end();
    reg_rd(7'h01, d); chk("R10 partial byte dropped", d, 8'h44);
    chk("R1 miso idle", spi_miso, 0);
  endtask

  initial begin
    repeat (4) @(negedge pclk);
    rst_n = 1;
    repeat (2) @(negedge pclk);
    t_reset();
    t_pointers();
    t_bypass();
    t_fill();
    t_wrap();
    t_enable();
    t_reserved();
    t_abort();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge pclk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule